// File: doc/BRIEF.md
# Exception Vector Dispatch Sequencer

This block carries out exception entry and exception return for a small 16-bit processor core. On an entry request it takes a vector index, forms the address of that vector's slot in a dispatch table, and fetches the 16-bit slot over a synchronous read port with one cycle of latency. It turns the slot into a 21-bit handler address. It saves the status word and the program counter on an interrupt stack that grows toward address zero, then presents the new program counter with a one-cycle `done` pulse.

On a return request it pops the two saved words back, rebuilds the program counter and status word, and moves the stack pointer up by four bytes. The table base and the stack pointer are registers inside the block. They are loaded through write strobes while the sequencer is idle, and their values are visible on outputs.

Top module: `excDispatchSeq`

## Requirements
- R1: The table base keeps only bits 15:1 of a write, so bits 20:16 and bit 0 always read 0. The stack pointer keeps every written bit except bit 0, which reads 0. Both registers reset to 0.
- R2: A base or stack-pointer write that arrives while `busy` is high has no effect.
- R3: An accepted entry issues exactly one read, in the first busy cycle, at address base + 2 × vector.
- R4: At the end of an entry, `newPc` equals {0, slot[15:0], 0}, zero-extended to 21 bits, and `newPsr` equals the status word captured at acceptance.
- R5: Entry writes the status word at SP−2 in the second busy cycle. It then writes program-counter bits 16:1 at SP−4 in the third busy cycle. SP reads SP−4 from the fourth busy cycle on.
- R6: A return reads address SP in its first busy cycle and SP+2 in its second busy cycle. It then presents `newPc` = {0, word@SP, 0} and `newPsr` = word@SP+2, and SP becomes SP+4. Nested entries unwind last-in first-out.
- R7: Both sequences take four busy cycles. `done` is high in the fourth busy cycle only, and low in the cycle after it.
- R8: `busy` is high from the cycle after acceptance until the `done` cycle. A start held high during a sequence is accepted in the first idle cycle that follows.
- R9: A start with a vector index of 48 or more is ignored. No busy cycle and no memory access follow.
- R10: When a valid start and a return are requested in the same idle cycle, the entry sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWrEn | input | 1 | Load strobe for the table base |
| baseWrData | input | 21 | Value for the table base |
| ispWrEn | input | 1 | Load strobe for the stack pointer |
| ispWrData | input | 21 | Value for the stack pointer |
| startReq | input | 1 | Entry request, held until accepted |
| retReq | input | 1 | Return request |
| vecIdx | input | 6 | Vector index for entry |
| curPc | input | 21 | Program counter to save |
| curPsr | input | 16 | Status word to save |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| newPc | output | 21 | Program counter to load, valid with done |
| newPsr | output | 16 | Status word, valid with done |
| baseOut | output | 21 | Current table base |
| ispOut | output | 21 | Current stack pointer |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 21 | Memory byte address |
| memWrData | output | 16 | Memory write data |
| memRdData | input | 16 | Read data, one cycle after memRdEn |

## Verification
The bench drives vectors 0 and 47 and a program counter with its upper bits set. A wrong doubling of the vector or a wrong pad on the slot would then give a wrong table address or handler. Two nested entries are unwound with two returns, which catches swapped push order or a return that pops the wrong slot. A start is held through a running sequence while base and stack-pointer writes arrive. A design that drops the held start, accepts it early, or lets those writes land would show a missing sequence, a shifted table address or a stack pointer that jumps. Vectors 48 and 63, and a start raised together with a return, check the range limit and the priority.

// File: rtl/excSeqPkg.sv
package excSeqPkg;

  typedef enum logic [2:0] {
    ADR_TABLE,
    ADR_ISP_M2,
    ADR_ISP_M4,
    ADR_ISP,
    ADR_ISP_P2
  } adrSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TBL_RD,
    ST_PUSH_PSR,
    ST_PUSH_PC,
    ST_POP_PC,
    ST_POP_PSR,
    ST_POP_END,
    ST_DONE
  } seqState_e;

  typedef struct packed {
    logic    latchReq;
    logic    memRd;
    logic    memWr;
    adrSel_e adrSel;
    logic    wrPcWord;
    logic    capEntry;
    logic    capPcWord;
    logic    capPsrWord;
    logic    ispDec;
    logic    ispInc;
  } seqStrobe_t;

endpackage

// File: rtl/excSeqCtrl.sv
module excSeqCtrl
  import excSeqPkg::*;
#(
  parameter int VEC_W   = 6,
  parameter int NUM_VEC = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             retReq,
  input  logic [VEC_W-1:0] vecIdx,
  output seqStrobe_t       strb,
  output logic             busy,
  output logic             done
);

  localparam logic [VEC_W:0] VEC_LIMIT = (VEC_W+1)'(NUM_VEC);

  seqState_e state, nextState;
  logic vecOk, takeStart, takeRet;

  assign vecOk     = {1'b0, vecIdx} < VEC_LIMIT;
  assign takeStart = (state == ST_IDLE) && startReq && vecOk;
  assign takeRet   = (state == ST_IDLE) && retReq && !takeStart;

  always_comb begin
    strb      = '0;
    strb.adrSel = ADR_TABLE;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (takeStart) begin
          strb.latchReq = 1'b1;
          nextState     = ST_TBL_RD;
        end else if (takeRet) begin
          nextState = ST_POP_PC;
        end
      end
      ST_TBL_RD: begin
        strb.memRd  = 1'b1;
        strb.adrSel = ADR_TABLE;
        nextState   = ST_PUSH_PSR;
      end
      ST_PUSH_PSR: begin
        strb.capEntry = 1'b1;
        strb.memWr    = 1'b1;
        strb.adrSel   = ADR_ISP_M2;
        nextState     = ST_PUSH_PC;
      end
      ST_PUSH_PC: begin
        strb.memWr    = 1'b1;
        strb.wrPcWord = 1'b1;
        strb.adrSel   = ADR_ISP_M4;
        strb.ispDec   = 1'b1;
        nextState     = ST_DONE;
      end
      ST_POP_PC: begin
        strb.memRd  = 1'b1;
        strb.adrSel = ADR_ISP;
        nextState   = ST_POP_PSR;
      end
      ST_POP_PSR: begin
        strb.memRd     = 1'b1;
        strb.adrSel    = ADR_ISP_P2;
        strb.capPcWord = 1'b1;
        nextState      = ST_POP_END;
      end
      ST_POP_END: begin
        strb.capPsrWord = 1'b1;
        strb.ispInc     = 1'b1;
        nextState       = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_PSR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPcWord |-> $past(strb.memWr && strb.adrSel == ADR_ISP_M2)); // R5
  AST_BAD_VEC_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && !vecOk && !retReq) |=> !busy); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memWr || strb.memRd) |-> busy); // R8

endmodule

// File: rtl/excSeqDpath.sv
module excSeqDpath
  import excSeqPkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int VEC_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              busy,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              ispWrEn,
  input  logic [ADDR_W-1:0] ispWrData,
  input  logic [VEC_W-1:0]  vecIdx,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [DATA_W-1:0] curPsr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [ADDR_W-1:0] baseOut,
  output logic [ADDR_W-1:0] ispOut,
  output logic [ADDR_W-1:0] newPc,
  output logic [DATA_W-1:0] newPsr
);

  localparam logic [ADDR_W-1:0] BASE_MASK = ADDR_W'((64'd1 << DATA_W) - 64'd2);
  localparam logic [ADDR_W-1:0] ISP_MASK  = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP2     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP4     = ADDR_W'(4);

  logic [ADDR_W-1:0] baseReg, ispReg, pcReg, newPcReg;
  logic [DATA_W-1:0] psrReg, newPsrReg;
  logic [VEC_W-1:0]  vecReg;
  logic [ADDR_W-1:0] tableAddr, padded;

  assign tableAddr = baseReg + ADDR_W'({vecReg, 1'b0});
  assign padded    = ADDR_W'({1'b0, memRdData, 1'b0});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
    end else if (baseWrEn && !busy) begin
      baseReg <= baseWrData & BASE_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ispReg <= '0;
    end else if (strb.ispDec) begin
      ispReg <= ispReg - STEP4;
    end else if (strb.ispInc) begin
      ispReg <= ispReg + STEP4;
    end else if (ispWrEn && !busy) begin
      ispReg <= ispWrData & ISP_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg    <= '0;
      pcReg     <= '0;
      psrReg    <= '0;
      newPcReg  <= '0;
      newPsrReg <= '0;
    end else begin
      if (strb.latchReq) begin
        vecReg    <= vecIdx;
        pcReg     <= curPc;
        psrReg    <= curPsr;
        newPsrReg <= curPsr;
      end
      if (strb.capEntry || strb.capPcWord) newPcReg <= padded;
      if (strb.capPsrWord)                 newPsrReg <= memRdData;
    end
  end

  always_comb begin
    unique case (strb.adrSel)
      ADR_TABLE:  memAddr = tableAddr;
      ADR_ISP_M2: memAddr = ispReg - STEP2;
      ADR_ISP_M4: memAddr = ispReg - STEP4;
      ADR_ISP:    memAddr = ispReg;
      ADR_ISP_P2: memAddr = ispReg + STEP2;
      default:    memAddr = tableAddr;
    endcase
  end

  assign memWrData = strb.wrPcWord ? pcReg[DATA_W:1] : psrReg;
  assign baseOut   = baseReg;
  assign ispOut    = ispReg;
  assign newPc     = newPcReg;
  assign newPsr    = newPsrReg;

  AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(baseReg)); // R2
  AST_ENTRY_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.capEntry |-> $past(strb.memRd)); // R3

endmodule

// File: rtl/excDispatchSeq.sv
module excDispatchSeq
  import excSeqPkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int VEC_W   = 6,
  parameter int NUM_VEC = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              ispWrEn,
  input  logic [ADDR_W-1:0] ispWrData,
  input  logic              startReq,
  input  logic              retReq,
  input  logic [VEC_W-1:0]  vecIdx,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [DATA_W-1:0] curPsr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] newPc,
  output logic [DATA_W-1:0] newPsr,
  output logic [ADDR_W-1:0] baseOut,
  output logic [ADDR_W-1:0] ispOut,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);

  seqStrobe_t strb;

  excSeqCtrl #(.VEC_W(VEC_W), .NUM_VEC(NUM_VEC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .retReq   (retReq),
    .vecIdx   (vecIdx),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  excSeqDpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busy       (busy),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .ispWrEn    (ispWrEn),
    .ispWrData  (ispWrData),
    .vecIdx     (vecIdx),
    .curPc      (curPc),
    .curPsr     (curPsr),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .baseOut    (baseOut),
    .ispOut     (ispOut),
    .newPc      (newPc),
    .newPsr     (newPsr)
  );

  assign memRdEn = strb.memRd;
  assign memWrEn = strb.memWr;

  AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R8

endmodule

// File: tb/excDispatchSeq_tb.sv
`timescale 1ns/1ps
module excDispatchSeq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0, ispWrEn = 1'b0, startReq = 1'b0, retReq = 1'b0;
  logic [20:0] baseWrData = '0, ispWrData = '0, curPc = '0;
  logic [5:0]  vecIdx = '0;
  logic [15:0] curPsr = '0;
  logic        busy, done, memRdEn, memWrEn;
  logic [20:0] newPc, baseOut, ispOut, memAddr;
  logic [15:0] newPsr, memWrData;
  logic [15:0] memRdData = '0;
  logic [15:0] memArr [0:4095];

  always #2.5 clk = ~clk;

  excDispatchSeq u_dut (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .ispWrEn(ispWrEn), .ispWrData(ispWrData), .startReq(startReq), .retReq(retReq),
    .vecIdx(vecIdx), .curPc(curPc), .curPsr(curPsr), .busy(busy), .done(done),
    .newPc(newPc), .newPsr(newPsr), .baseOut(baseOut), .ispOut(ispOut),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData)
  );

  // Memory with one cycle read latency
  always @(posedge clk) begin
    if (memWrEn) memArr[memAddr[11:0]] <= memWrData;
    if (memRdEn) memRdData <= memArr[memAddr[11:0]];
  end

  typedef struct {
    bit busy; bit rd; bit wr; int addr; int wdata;
    bit done; int pc; int psr; int isp; string tag;
  } expRec_t;

  expRec_t expQ[$];
  int nChk = 0, nFail = 0;
  bit chkOn = 0, finished = 0;
  int modelBase = 0, modelIsp = 0;
  int stackPc[$], stackPsr[$];

  function automatic int slotVal(int v);
    return (16'h1234 + v * 16'h0531) & 16'hFFFF;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic expRec_t mk(bit b, bit rd, bit wr, int a, int wd, bit d,
                                 int pc, int psr, int isp, string tag);
    expRec_t r;
    r.busy = b; r.rd = rd; r.wr = wr; r.addr = a; r.wdata = wd;
    r.done = d; r.pc = pc; r.psr = psr; r.isp = isp; r.tag = tag;
    return r;
  endfunction

  // Per-cycle comparison against the reference queue
  always @(negedge clk) begin
    expRec_t r;
    if (chkOn && !finished) begin
      if (expQ.size() > 0) r = expQ.pop_front();
      else r = mk(0, 0, 0, 0, 0, 0, -1, -1, -1, "R8_idle");
      chk(busy == r.busy, r.tag, "busy", busy, r.busy);
      chk(memRdEn == r.rd, r.tag, "memRdEn", memRdEn, r.rd);
      chk(memWrEn == r.wr, r.tag, "memWrEn", memWrEn, r.wr);
      chk(done == r.done, r.tag, "done", done, r.done);
      if (r.rd || r.wr) chk(memAddr == 21'(r.addr), r.tag, "memAddr", memAddr, r.addr);
      if (r.wr) chk(memWrData == 16'(r.wdata), r.tag, "memWrData", memWrData, r.wdata);
      if (r.pc >= 0) chk(newPc == 21'(r.pc), r.tag, "newPc", newPc, r.pc);
      if (r.psr >= 0) chk(newPsr == 16'(r.psr), r.tag, "newPsr", newPsr, r.psr);
      if (r.isp >= 0) chk(ispOut == 21'(r.isp), r.tag, "ispOut", ispOut, r.isp);
    end
  end

  function automatic void pushEntry(int v, int pc, int psr, string tag);
    int ta, sp, pw;
    ta = (modelBase + 2 * v) & 32'h1FFFFF;
    sp = modelIsp;
    pw = (pc >> 1) & 32'hFFFF;
    expQ.push_back(mk(0, 0, 0, 0, 0, 0, -1, -1, sp, {tag, "_R8_accept"}));
    expQ.push_back(mk(1, 1, 0, ta, 0, 0, -1, -1, sp, {tag, "_R3_table"}));
    expQ.push_back(mk(1, 0, 1, sp - 2, psr, 0, -1, -1, sp, {tag, "_R5_psr"}));
    expQ.push_back(mk(1, 0, 1, sp - 4, pw, 0, -1, -1, sp, {tag, "_R5_pc"}));
    expQ.push_back(mk(1, 0, 0, 0, 0, 1, slotVal(v) << 1, psr, sp - 4, {tag, "_R4_R7_done"}));
    modelIsp = sp - 4;
    stackPc.push_back(pw);
    stackPsr.push_back(psr);
  endfunction

  function automatic void pushReturn(string tag);
    int sp, pw, ps;
    sp = modelIsp;
    pw = stackPc.pop_back();
    ps = stackPsr.pop_back();
    expQ.push_back(mk(0, 0, 0, 0, 0, 0, -1, -1, sp, {tag, "_R8_accept"}));
    expQ.push_back(mk(1, 1, 0, sp, 0, 0, -1, -1, sp, {tag, "_R6_rdpc"}));
    expQ.push_back(mk(1, 1, 0, sp + 2, 0, 0, -1, -1, sp, {tag, "_R6_rdpsr"}));
    expQ.push_back(mk(1, 0, 0, 0, 0, 0, -1, -1, sp, {tag, "_R6_R7_wait"}));
    expQ.push_back(mk(1, 0, 0, 0, 0, 1, pw << 1, ps, sp + 4, {tag, "_R6_R7_done"}));
    modelIsp = sp + 4;
  endfunction

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doEntry(int v, int pc, int psr, string tag);
    @(posedge clk); #1;
    startReq = 1; vecIdx = 6'(v); curPc = 21'(pc); curPsr = 16'(psr);
    pushEntry(v, pc, psr, tag);
    @(posedge clk); #1;
    startReq = 0;
    drain();
  endtask

  task automatic doReturn(string tag);
    @(posedge clk); #1;
    retReq = 1;
    pushReturn(tag);
    @(posedge clk); #1;
    retReq = 0;
    drain();
  endtask

  task automatic wrBase(int d, int expv);
    @(posedge clk); #1; baseWrEn = 1; baseWrData = 21'(d);
    @(posedge clk); #1; baseWrEn = 0;
    @(negedge clk);
    chk(baseOut == 21'(expv), "R1", "baseOut", baseOut, expv);
    modelBase = expv;
  endtask

  task automatic wrIsp(int d, int expv);
    @(posedge clk); #1; ispWrEn = 1; ispWrData = 21'(d);
    @(posedge clk); #1; ispWrEn = 0;
    @(negedge clk);
    chk(ispOut == 21'(expv), "R1", "ispOut", ispOut, expv);
    modelIsp = expv;
  endtask

  task automatic badVec(int v);
    @(posedge clk); #1; startReq = 1; vecIdx = 6'(v);
    for (int i = 0; i < 3; i++) expQ.push_back(mk(0, 0, 0, 0, 0, 0, -1, -1, modelIsp, "R9_badvec"));
    repeat (3) @(posedge clk);
    #1; startReq = 0;
    drain();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog run did not complete");
    finish();
  end

  initial begin
    for (int i = 0; i < 4096; i++) memArr[i] = 16'h0;
    for (int v = 0; v < 48; v++) memArr[12'h400 + 2 * v] = 16'(slotVal(v));
    repeat (4) @(posedge clk);
    #1; rstN = 1;
    @(negedge clk);
    chk(busy == 0, "R8", "reset busy", busy, 0);
    chk(done == 0, "R7", "reset done", done, 0);
    chk(baseOut == 0, "R1", "reset base", baseOut, 0);
    chk(ispOut == 0, "R1", "reset isp", ispOut, 0);
    chkOn = 1;

    // R1 masking of base and stack pointer
    wrBase(21'h1FFFFF, 21'h00FFFE);
    wrBase(21'h1F0401, 21'h000400);
    wrIsp(21'h000801, 21'h000800);

    // R3 R4 R5 R7: single entries and returns
    doEntry(0, 21'h1ABCDE, 16'hA5C3, "E0");
    doReturn("X0");
    doEntry(47, 21'h000102, 16'h0001, "E47");
    doReturn("X47");

    // R6 nested unwinding
    doEntry(5, 21'h012346, 16'h1111, "N1");
    doEntry(9, 21'h0FFFFE, 16'h2222, "N2");
    doReturn("U2");
    doReturn("U1");

    // R8 held start and R2 writes ignored while busy
    @(posedge clk); #1;
    startReq = 1; vecIdx = 6'd3; curPc = 21'h000AAA; curPsr = 16'h3333;
    pushEntry(3, 21'h000AAA, 16'h3333, "H1");
    pushEntry(20, 21'h004444, 16'h4444, "H2");
    @(posedge clk); #1;
    vecIdx = 6'd20; curPc = 21'h004444; curPsr = 16'h4444;
    baseWrEn = 1; baseWrData = 21'h000600; ispWrEn = 1; ispWrData = 21'h000100;
    @(posedge clk); #1;
    baseWrEn = 0; ispWrEn = 0;
    repeat (4) @(posedge clk);
    #1; startReq = 0;
    drain();
    chk(baseOut == 21'(modelBase), "R2", "base after busy write", baseOut, modelBase);
    doReturn("HX2");
    doReturn("HX1");

    // R9 out-of-range vectors
    badVec(48);
    badVec(63);

    // R10 start wins over return
    @(posedge clk); #1;
    startReq = 1; retReq = 1; vecIdx = 6'd12; curPc = 21'h0055AA; curPsr = 16'h7E7E;
    pushEntry(12, 21'h0055AA, 16'h7E7E, "R10_both");
    @(posedge clk); #1;
    startReq = 0; retReq = 0;
    drain();
    doReturn("R10_ret");

    repeat (3) @(negedge clk);
    finish();
  end

endmodule